// File: doc/BRIEF.md
# Lockstep Dual-Channel Safety Comparator

This block supervises two identical processing channels that run in lockstep. It has one shared step sequencer. The sequencer sends a step strobe to each channel. A fixed number of cycles later it sends a check strobe to an internal comparator. On that check strobe, the comparator samples both channels' bus words and their valid flags. If they agree, it reports OK.

The OK result is carried on two complementary rails. Both rails invert on every passing check, so a stuck output can never look like a fresh OK. A detected OK is the only thing that lets the sequencer issue the next step.

When OK does not arrive inside a fixed window, the block stops stepping and raises a latched safe-state output. This happens after a word mismatch, a missing valid flag, or an inconsistent pair of OK rails. Only reset clears the safe state. A counter of accepted steps is kept for diagnostics.

Top module: `lockstep_cmp`

## Requirements
- R1: While reset is held, and after it, the outputs are as follows until the first step: step_a, step_b, chk_strobe and safe_state are low, ok_true is 0, ok_false is 1 and step_cnt is 0.
- R2: The first step is issued without any condition. It is due in the cycle after the first clock edge with rst low. step_a and step_b are always high together, for one cycle per step.
- R3: chk_strobe is high for one cycle, exactly CHK_DLY cycles after each step strobe.
- R4: When both valid flags are 1 and the two words are equal in the check cycle, ok_true and ok_false both invert in the next cycle. The two rails are always opposite. Equal rails, or a rail change outside the wait window after a check, count as a comparator fault and enter safe state.
- R5: The next step strobe comes in the cycle after the OK rails change. A clean run therefore steps every CHK_DLY+2 cycles.
- R6: If the two words differ in any bit in the check cycle, the OK rails do not change. safe_state rises TMO+1 cycles after that check cycle, and no further step or check strobe is issued.
- R7: A valid flag that is 0 on either channel in the check cycle is treated exactly like a mismatch (R6), even when the words are equal.
- R8: safe_state stays high once it is set, with step and check strobes low and the OK rails frozen. Only reset returns the block to its R1 state.
- R9: Channel words and valid flags in any cycle other than the check cycle have no effect on the OK rails, the strobes or safe_state.
- R10: step_cnt rises by one in the cycle after each OK rail change, that is, in the cycle of the next step. It does not change in safe state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cha_word | input | W | Bus word of channel A |
| cha_vld | input | 1 | Channel A word valid |
| chb_word | input | W | Bus word of channel B |
| chb_vld | input | 1 | Channel B word valid |
| step_a | output | 1 | Step strobe to channel A |
| step_b | output | 1 | Step strobe to channel B |
| chk_strobe | output | 1 | Comparator sampling strobe |
| ok_true | output | 1 | OK rail, inverts on each passing check |
| ok_false | output | 1 | Complementary OK rail |
| safe_state | output | 1 | Latched safe-side indication |
| step_cnt | output | CNT_W | Number of accepted steps |

## Verification
Taking a step strobe in cycle s as the reference, the check strobe is due in cycle s+CHK_DLY. The rail change and the next step are due in s+CHK_DLY+1 and s+CHK_DLY+2, and a failed check raises safe_state in s+CHK_DLY+TMO+1.

The bench keeps its own cycle index from reset release, and derives each of these due cycles from the step index and the chosen fault step. It compares every output on the falling edge of each cycle, so a result that comes one cycle early or late is reported in the cycle where it differs. Inputs outside the check cycle are driven with random words and flags, so any dependence on them shows up in the same per-cycle comparison.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [2:0] {
        GS_BOOT,
        GS_STEP,
        GS_EXEC,
        GS_CHECK,
        GS_WAIT,
        GS_SAFE
    } gen_state_e;

    typedef struct packed {
        logic t;
        logic f;
    } ok_rail_t;

    localparam ok_rail_t RAIL_RESET = '{t: 1'b0, f: 1'b1};

    function automatic logic rails_valid(ok_rail_t r);
        return r.t ^ r.f;
    endfunction

    function automatic ok_rail_t rails_flip(ok_rail_t r);
        return '{t: ~r.t, f: ~r.f};
    endfunction

endpackage

// File: rtl/lsc_compare.sv
module lsc_compare
    import lsc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         chk,
    input  logic [W-1:0] a_word,
    input  logic         a_vld,
    input  logic [W-1:0] b_word,
    input  logic         b_vld,
    output ok_rail_t     rail
);
    logic [W-1:0] diff;
    logic         eq_xor;
    logic         eq_cmp;
    logic         pass;

    // bitwise difference vector, one slice per bit
    for (genvar i = 0; i < W; i++) begin : g_diff
        assign diff[i] = a_word[i] ^ b_word[i];
    end

    // two independently formed equality terms; both must agree to pass
    assign eq_xor = ~|diff;
    assign eq_cmp = (a_word == b_word);
    assign pass   = chk & a_vld & b_vld & eq_xor & eq_cmp;

    always_ff @(posedge clk) begin
        if (rst) begin
            rail <= RAIL_RESET;
        end else if (pass) begin
            rail <= rails_flip(rail);
        end
    end
endmodule

// File: rtl/lsc_okmon.sv
module lsc_okmon
    import lsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wait_open,
    input  ok_rail_t rail,
    output logic     accept,
    output logic     fault
);
    logic seen;
    logic moved;

    assign moved  = (rail.t != seen);
    assign accept = wait_open & moved & rails_valid(rail);
    assign fault  = ~rails_valid(rail) | (moved & ~wait_open);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= RAIL_RESET.t;
        end else if (accept) begin
            seen <= rail.t;
        end
    end
endmodule

// File: rtl/lsc_stepgen.sv
module lsc_stepgen
    import lsc_pkg::*;
#(
    parameter int CHK_DLY = 2,
    parameter int TMO     = 4,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             fault,
    output logic             step,
    output logic             chk,
    output logic             wait_open,
    output logic             safe,
    output logic [CNT_W-1:0] step_cnt
);
    localparam int TMAX = (CHK_DLY > TMO) ? CHK_DLY : TMO;
    localparam int DW   = $clog2(TMAX + 1);

    localparam logic [DW-1:0] EXEC_LAST = DW'(CHK_DLY - 1);
    localparam logic [DW-1:0] WAIT_LAST = DW'(TMO - 1);

    gen_state_e       st;
    logic [DW-1:0]    tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= GS_BOOT;
            tmr      <= '0;
            step_cnt <= '0;
        end else if (fault && st != GS_SAFE) begin
            st <= GS_SAFE;
        end else begin
            unique case (st)
                GS_BOOT: st <= GS_STEP;
                GS_STEP: begin
                    tmr <= DW'(1);
                    st  <= (CHK_DLY == 1) ? GS_CHECK : GS_EXEC;
                end
                GS_EXEC: begin
                    if (tmr == EXEC_LAST) st <= GS_CHECK;
                    else                  tmr <= tmr + DW'(1);
                end
                GS_CHECK: begin
                    tmr <= '0;
                    st  <= GS_WAIT;
                end
                GS_WAIT: begin
                    if (accept) begin
                        st       <= GS_STEP;
                        step_cnt <= step_cnt + CNT_W'(1);
                    end else if (tmr == WAIT_LAST) begin
                        st <= GS_SAFE;
                    end else begin
                        tmr <= tmr + DW'(1);
                    end
                end
                GS_SAFE: st <= GS_SAFE;
                default: st <= GS_SAFE;
            endcase
        end
    end

    assign step      = (st == GS_STEP);
    assign chk       = (st == GS_CHECK);
    assign wait_open = (st == GS_WAIT);
    assign safe      = (st == GS_SAFE);
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
    import lsc_pkg::*;
#(
    parameter int W       = 16,
    parameter int CHK_DLY = 2,
    parameter int TMO     = 4,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     cha_word,
    input  logic             cha_vld,
    input  logic [W-1:0]     chb_word,
    input  logic             chb_vld,
    output logic             step_a,
    output logic             step_b,
    output logic             chk_strobe,
    output logic             ok_true,
    output logic             ok_false,
    output logic             safe_state,
    output logic [CNT_W-1:0] step_cnt
);
    ok_rail_t rail;
    logic     step;
    logic     wait_open;
    logic     accept;
    logic     fault;

    lsc_compare #(.W(W)) u_compare (
        .clk    (clk),
        .rst    (rst),
        .chk    (chk_strobe),
        .a_word (cha_word),
        .a_vld  (cha_vld),
        .b_word (chb_word),
        .b_vld  (chb_vld),
        .rail   (rail)
    );

    lsc_okmon u_okmon (
        .clk       (clk),
        .rst       (rst),
        .wait_open (wait_open),
        .rail      (rail),
        .accept    (accept),
        .fault     (fault)
    );

    lsc_stepgen #(.CHK_DLY(CHK_DLY), .TMO(TMO), .CNT_W(CNT_W)) u_stepgen (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .fault     (fault),
        .step      (step),
        .chk       (chk_strobe),
        .wait_open (wait_open),
        .safe      (safe_state),
        .step_cnt  (step_cnt)
    );

    assign step_a   = step;
    assign step_b   = step;
    assign ok_true  = rail.t;
    assign ok_false = rail.f;
endmodule

// File: rtl/lockstep_cmp_chk.sv
module lockstep_cmp_chk #(
    parameter int CHK_DLY = 2,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             step_a,
    input logic             step_b,
    input logic             chk_strobe,
    input logic             ok_true,
    input logic             ok_false,
    input logic             safe_state,
    input logic [CNT_W-1:0] step_cnt
);
    logic [15:0] since_step;

    always_ff @(posedge clk) begin
        if (rst)                  since_step <= '0;
        else if (step_a)          since_step <= 16'd1;
        else if (since_step != '1) since_step <= since_step + 16'd1;
    end

    assert_strobes_paired_R2: assert property (@(posedge clk) disable iff (rst)
        step_a == step_b);

    assert_chk_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        chk_strobe |-> since_step == 16'(CHK_DLY));

    assert_rails_opposite_R4: assert property (@(posedge clk) disable iff (rst)
        ok_true != ok_false);

    assert_rail_needs_chk_R4: assert property (@(posedge clk) disable iff (rst)
        !chk_strobe |=> $stable(ok_true));

    assert_safe_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        safe_state |=> safe_state);

    assert_safe_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        safe_state |-> (!step_a && !chk_strobe));

    assert_cnt_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        safe_state |=> $stable(step_cnt));
endmodule

bind lockstep_cmp lockstep_cmp_chk #(.CHK_DLY(CHK_DLY), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_a     (step_a),
    .step_b     (step_b),
    .chk_strobe (chk_strobe),
    .ok_true    (ok_true),
    .ok_false   (ok_false),
    .safe_state (safe_state),
    .step_cnt   (step_cnt)
);

// File: tb/test_lockstep_cmp.sv
`timescale 1ns/1ps
module test_lockstep_cmp;
    localparam int W       = 16;
    localparam int CHK_DLY = 2;
    localparam int TMO     = 4;
    localparam int CNT_W   = 16;
    localparam int P       = CHK_DLY + 2;
    localparam int NONE    = 1 << 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [W-1:0]     cha_word = '0;
    logic             cha_vld = 1'b0;
    logic [W-1:0]     chb_word = '0;
    logic             chb_vld = 1'b0;
    logic             step_a, step_b, chk_strobe, ok_true, ok_false, safe_state;
    logic [CNT_W-1:0] step_cnt;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    lockstep_cmp #(.W(W), .CHK_DLY(CHK_DLY), .TMO(TMO), .CNT_W(CNT_W)) i_lockstep_cmp (
        .clk(clk), .rst(rst),
        .cha_word(cha_word), .cha_vld(cha_vld),
        .chb_word(chb_word), .chb_vld(chb_vld),
        .step_a(step_a), .step_b(step_b), .chk_strobe(chk_strobe),
        .ok_true(ok_true), .ok_false(ok_false),
        .safe_state(safe_state), .step_cnt(step_cnt)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // steps whose rail change (offset) is visible by cycle k, capped at the fault step
    function automatic int done_by(input int k, input int offs, input int bad);
        int n;
        if (k < offs) return 0;
        n = (k - offs) / P + 1;
        return (n < bad) ? n : bad;
    endfunction

    task automatic drive_junk();
        cha_word = W'($urandom);
        chb_word = W'($urandom);
        cha_vld  = 1'($urandom);
        chb_vld  = 1'($urandom);
    endtask

    // kind: 0 random word diff, 1 A invalid, 2 B invalid, 3 single MSB diff, 4 both invalid
    task automatic drive_check(input bit faulty, input int kind);
        logic [W-1:0] d;
        d = W'($urandom);
        cha_word = d; chb_word = d; cha_vld = 1'b1; chb_vld = 1'b1;
        if (faulty) begin
            case (kind)
                0: chb_word = d ^ (W'($urandom) | W'(1));
                1: cha_vld = 1'b0;
                2: chb_vld = 1'b0;
                3: chb_word = d ^ {1'b1, {(W-1){1'b0}}};
                default: begin cha_vld = 1'b0; chb_vld = 1'b0; end
            endcase
        end
    endtask

    task automatic run_case(input int nsteps, input int bad_in, input int kind);
        int bad, k_safe, kmax;
        string sreq;
        bad    = (bad_in < 0) ? NONE : bad_in;
        k_safe = 2 + bad * P + CHK_DLY + TMO;
        kmax   = (bad_in < 0) ? nsteps * P + 2 : k_safe + 3 * P;
        sreq   = (kind == 1 || kind == 2 || kind == 4) ? "R7" : "R6";
        rst = 1'b1;
        drive_junk();
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset values (also R8: reset clears a previous safe state)
        check(!step_a && !step_b && !chk_strobe, "R1 strobes", int'(step_a), 0);
        check(!safe_state, "R1 R8 safe", int'(safe_state), 0);
        check(ok_true == 1'b0 && ok_false == 1'b1, "R1 rails", int'({ok_true, ok_false}), 1);
        check(step_cnt == '0, "R1 cnt", int'(step_cnt), 0);
        rst = 1'b0;
        for (int k = 1; k <= kmax; k++) begin
            bit e_safe, e_step, e_chk, e_ok;
            int ph, n, e_cnt;
            @(negedge clk);
            e_safe = (k >= k_safe);
            ph = (k - 1) % P;
            n  = (k - 1) / P;
            e_step = !e_safe && ph == 0 && n <= bad;
            e_chk  = !e_safe && ph == CHK_DLY && n <= bad;
            e_ok   = 1'(done_by(k, 2 + CHK_DLY, bad) & 1);
            e_cnt  = done_by(k, 3 + CHK_DLY, bad);
            check(step_a == e_step && step_b == e_step,
                  e_safe ? "R8 step" : (k == 1 ? "R2 first step" : "R5 step"),
                  int'({step_a, step_b}), int'({e_step, e_step}));
            check(chk_strobe == e_chk, e_safe ? "R8 chk" : "R3 chk",
                  int'(chk_strobe), int'(e_chk));
            check(safe_state == e_safe, sreq, int'(safe_state), int'(e_safe));
            check(ok_true == e_ok && ok_false == !e_ok, "R4 R9 rails",
                  int'({ok_true, ok_false}), int'({e_ok, !e_ok}));
            check(int'(step_cnt) == e_cnt, "R10 cnt", int'(step_cnt), e_cnt);
            if (e_chk) drive_check(n == bad, kind);
            else       drive_junk();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_case(8, -1, 0);   // clean run, R5 period
        run_case(4, 0, 0);    // mismatch on first step
        run_case(6, 2, 1);    // A invalid
        run_case(6, 3, 2);    // B invalid
        run_case(5, 1, 3);    // single MSB difference
        run_case(5, 2, 4);    // both invalid, equal words
        for (int r = 0; r < 25; r++) begin
            int ns, bd;
            ns = 2 + int'($urandom % 9);
            bd = ($urandom % 4 == 0) ? -1 : int'($urandom % ns);
            run_case(ns, bd, int'($urandom % 5));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule